// File: doc/BRIEF.md
# Bus Access Sizing and Alignment Unit

This block connects a processor core to an external bus that is 16 bits wide and addressed by byte. The core places one request at a time. Each request carries a byte address, a size code (byte, 16-bit word or 32-bit long word), a direction, 32 bits of write data and a cycle-type code. The block turns each request into one or two handshaked bus cycles. It drives the word-address lines, one strobe for each byte lane, the read/write line and the cycle-type code. A cycle holds until the external side returns an acknowledge.

Data is big-endian. The even byte of a word travels on the upper lane (bits 15:8) and the odd byte on the lower lane (bits 7:0). A long word is carried as two word cycles, one after the other. The more significant half goes at the request address and the less significant half at the next word address. A word or long request at an odd address is refused: the block pulses an address-error output and starts no bus cycle.

Top module: `bus_sizer`

## Requirements
- R1: After reset, bus_as, bus_uds, bus_lds, rsp_done and rsp_addr_err are low, bus_rw is high and req_ready is high.
- R2: A request with req_size other than 2'b00 (byte) and req_addr[0]=1 makes rsp_addr_err high for exactly one cycle, starting the cycle after acceptance. bus_as does not rise, rsp_done stays low and req_ready stays high.
- R3: The strobes are active high. A byte access at an even address raises only bus_uds. A byte access at an odd address raises only bus_lds. A word or long access raises both.
- R4: bus_addr carries req_addr[ADDR_W-1:1]. The second half of a long access uses that word address plus one, taken modulo 2^(ADDR_W-1).
- R5: While bus_as is high and bus_ack has not been sampled high, bus_as, bus_addr, both strobes, bus_rw, bus_fc and bus_dout hold their values.
- R6: A long access runs two bus cycles. After the first acknowledge, bus_as is low for exactly one cycle and then rises for the second half.
- R7: On a long read, the first returned word forms rsp_rdata[31:16] and the second forms rsp_rdata[15:0]. rsp_done does not rise after the first acknowledge.
- R8: On a long write, bus_dout carries req_wdata[31:16] in the first cycle and req_wdata[15:0] in the second. bus_rw is low (write) through both halves and the gap between them.
- R9: A byte read returns the addressed lane (upper lane for even, lower lane for odd), zero-extended in rsp_rdata. A word read returns bus_din zero-extended. A byte write drives req_wdata[7:0] on both lanes. A word write drives req_wdata[15:0].
- R10: req_ready is low from acceptance until the cycle in which rsp_done is high. A request presented while req_ready is low is ignored.
- R11: bus_fc carries the request's req_fc through every bus cycle of the access, including both halves of a long access.
- R12: rsp_done is a one-cycle pulse in the cycle after the final acknowledge is sampled. bus_as is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | 2 | 00 byte, 01 word, 1x long word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| req_fc | input | FC_W | Cycle-type code |
| rsp_done | output | 1 | Access finished pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| rsp_addr_err | output | 1 | Misaligned request pulse |
| bus_addr | output | ADDR_W-1 | Word address lines |
| bus_as | output | 1 | Address strobe, high during a cycle |
| bus_uds | output | 1 | Upper byte lane strobe |
| bus_lds | output | 1 | Lower byte lane strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_fc | output | FC_W | Cycle-type code on the bus |
| bus_dout | output | 16 | Write data on the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
The bench builds the block with ADDR_W=12 and the default FC_W=3. The narrow address makes the top word address 0x7FF easy to reach, so a long access at byte address 0xFFE shows its second half wrapping to word address 0. The bench varies the number of wait cycles before each acknowledge, so the hold behaviour is seen both with and without waits. It also raises a competing request in the middle of a split write, to show that the request is dropped.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 2 * BYTE_W;
  localparam int WIDE_W = 2 * BUS_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bsz_align_chk.sv
module bsz_align_chk (
  input  logic [1:0] size,
  input  logic       addr0,
  output logic       is_byte,
  output logic       is_long,
  output logic       misalign
);
  always_comb begin
    is_byte  = (size == 2'b00);
    is_long  = size[1];
    misalign = !is_byte && addr0;
  end
endmodule

// File: rtl/bsz_lane_map.sv
module bsz_lane_map
  import bus_sizer_pkg::*;
(
  input  logic              sel_byte,
  input  logic              addr0,
  input  logic              sel_hi,
  input  logic [WIDE_W-1:0] wdata,
  output logic              uds,
  output logic              lds,
  output logic [BUS_W-1:0]  dout
);
  always_comb begin
    if (sel_byte) begin
      uds  = !addr0;
      lds  = addr0;
      dout = {2{wdata[BYTE_W-1:0]}};
    end else begin
      uds  = 1'b1;
      lds  = 1'b1;
      dout = sel_hi ? wdata[WIDE_W-1:BUS_W] : wdata[BUS_W-1:0];
    end
  end
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
  import bus_sizer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic misalign,
  input  logic bus_ack,
  input  logic lat_long,
  output logic req_ready,
  output logic accept_ok,
  output logic err_pulse,
  output logic ack_mid,
  output logic ack_last,
  output logic launch_second
);
  seq_state_e state_q;
  logic       half_q;
  logic       running;

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    running       = (state_q == ST_RUN);
    accept_ok     = req_ready && req_valid && !misalign;
    err_pulse     = req_ready && req_valid && misalign;
    ack_mid       = running && bus_ack && lat_long && !half_q;
    ack_last      = running && bus_ack && !(lat_long && !half_q);
    launch_second = (state_q == ST_GAP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_ok) begin
          state_q <= ST_RUN;
          half_q  <= 1'b0;
        end
        ST_RUN: begin
          if (ack_mid) begin
            state_q <= ST_GAP;
            half_q  <= 1'b1;
          end else if (ack_last) begin
            state_q <= ST_IDLE;
          end
        end
        ST_GAP:  state_q <= ST_RUN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsz_rd_assemble.sv
module bsz_rd_assemble
  import bus_sizer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_mid,
  input  logic              ack_last,
  input  logic              lat_byte,
  input  logic              lat_long,
  input  logic              lat_addr0,
  input  logic [BUS_W-1:0]  bus_din,
  output logic              rsp_done,
  output logic [WIDE_W-1:0] rsp_rdata
);
  logic [BUS_W-1:0]  hi_q;
  logic [BYTE_W-1:0] lane_byte;

  always_comb lane_byte = lat_addr0 ? bus_din[BYTE_W-1:0] : bus_din[BUS_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= ack_last;
      if (ack_mid) hi_q <= bus_din;
      if (ack_last) begin
        if (lat_long)      rsp_rdata <= {hi_q, bus_din};
        else if (lat_byte) rsp_rdata <= {{(WIDE_W-BYTE_W){1'b0}}, lane_byte};
        else               rsp_rdata <= {{(WIDE_W-BUS_W){1'b0}}, bus_din};
      end
    end
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bus_sizer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [WIDE_W-1:0] req_wdata,
  input  logic [FC_W-1:0]   req_fc,
  output logic              rsp_done,
  output logic [WIDE_W-1:0] rsp_rdata,
  output logic              rsp_addr_err,
  output logic [ADDR_W-2:0] bus_addr,
  output logic              bus_as,
  output logic              bus_uds,
  output logic              bus_lds,
  output logic              bus_rw,
  output logic [FC_W-1:0]   bus_fc,
  output logic [BUS_W-1:0]  bus_dout,
  input  logic [BUS_W-1:0]  bus_din,
  input  logic              bus_ack
);
  localparam int WADDR_W = ADDR_W - 1;

  logic               req_byte, req_long, misalign;
  logic               accept_ok, err_pulse, ack_mid, ack_last, launch_second;
  logic               lat_byte, lat_long, lat_addr0;
  logic [WADDR_W-1:0] lat_waddr;
  logic [WIDE_W-1:0]  lat_wdata;
  logic               map_byte, map_hi, map_uds, map_lds;
  logic [WIDE_W-1:0]  map_wdata;
  logic [BUS_W-1:0]   map_dout;

  bsz_align_chk u_align (
    .size     (req_size),
    .addr0    (req_addr[0]),
    .is_byte  (req_byte),
    .is_long  (req_long),
    .misalign (misalign)
  );

  bsz_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .misalign      (misalign),
    .bus_ack       (bus_ack),
    .lat_long      (lat_long),
    .req_ready     (req_ready),
    .accept_ok     (accept_ok),
    .err_pulse     (err_pulse),
    .ack_mid       (ack_mid),
    .ack_last      (ack_last),
    .launch_second (launch_second)
  );

  always_comb begin
    map_byte  = launch_second ? 1'b0 : req_byte;
    map_hi    = launch_second ? 1'b0 : req_long;
    map_wdata = launch_second ? lat_wdata : req_wdata;
  end

  bsz_lane_map u_lanes (
    .sel_byte (map_byte),
    .addr0    (req_addr[0]),
    .sel_hi   (map_hi),
    .wdata    (map_wdata),
    .uds      (map_uds),
    .lds      (map_lds),
    .dout     (map_dout)
  );

  bsz_rd_assemble u_rd (
    .clk       (clk),
    .rst       (rst),
    .ack_mid   (ack_mid),
    .ack_last  (ack_last),
    .lat_byte  (lat_byte),
    .lat_long  (lat_long),
    .lat_addr0 (lat_addr0),
    .bus_din   (bus_din),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_as       <= 1'b0;
      bus_uds      <= 1'b0;
      bus_lds      <= 1'b0;
      bus_rw       <= 1'b1;
      bus_addr     <= '0;
      bus_fc       <= '0;
      bus_dout     <= '0;
      rsp_addr_err <= 1'b0;
      lat_byte     <= 1'b0;
      lat_long     <= 1'b0;
      lat_addr0    <= 1'b0;
      lat_waddr    <= '0;
      lat_wdata    <= '0;
    end else begin
      rsp_addr_err <= err_pulse;
      if (accept_ok) begin
        lat_byte  <= req_byte;
        lat_long  <= req_long;
        lat_addr0 <= req_addr[0];
        lat_waddr <= req_addr[ADDR_W-1:1];
        lat_wdata <= req_wdata;
        bus_as    <= 1'b1;
        bus_addr  <= req_addr[ADDR_W-1:1];
        bus_uds   <= map_uds;
        bus_lds   <= map_lds;
        bus_rw    <= !req_write;
        bus_fc    <= req_fc;
        bus_dout  <= map_dout;
      end else if (launch_second) begin
        bus_as   <= 1'b1;
        bus_addr <= lat_waddr + {{(WADDR_W-1){1'b0}}, 1'b1};
        bus_uds  <= map_uds;
        bus_lds  <= map_lds;
        bus_dout <= map_dout;
      end else if (ack_mid || ack_last) begin
        bus_as  <= 1'b0;
        bus_uds <= 1'b0;
        bus_lds <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsz_checker.sv
module bsz_checker #(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_addr_err,
  input logic [ADDR_W-2:0] bus_addr,
  input logic              bus_as,
  input logic              bus_uds,
  input logic              bus_lds,
  input logic              bus_rw,
  input logic [FC_W-1:0]   bus_fc,
  input logic [15:0]       bus_dout,
  input logic              bus_ack
);
  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_addr_err |-> (!bus_as && req_ready)); // R2
  AST_STROBE_SET: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> (bus_uds || bus_lds)); // R3
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_as && !bus_ack) |=> (bus_as && $stable(bus_addr) && $stable(bus_uds) && $stable(bus_lds)
                              && $stable(bus_rw) && $stable(bus_fc) && $stable(bus_dout))); // R5
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_ack) |=> !bus_as); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> !req_ready); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> ($past(bus_as && bus_ack) && !bus_as)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R12
endmodule

bind bus_sizer bsz_checker #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .rsp_done     (rsp_done),
  .rsp_addr_err (rsp_addr_err),
  .bus_addr     (bus_addr),
  .bus_as       (bus_as),
  .bus_uds      (bus_uds),
  .bus_lds      (bus_lds),
  .bus_rw       (bus_rw),
  .bus_fc       (bus_fc),
  .bus_dout     (bus_dout),
  .bus_ack      (bus_ack)
);

// File: tb/bus_sizer_bench.sv
module bus_sizer_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int FC_W   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic              req_write = 1'b0;
  logic [31:0]       req_wdata = '0;
  logic [FC_W-1:0]   req_fc = '0;
  logic              rsp_done, rsp_addr_err;
  logic [31:0]       rsp_rdata;
  logic [ADDR_W-2:0] bus_addr;
  logic              bus_as, bus_uds, bus_lds, bus_rw;
  logic [FC_W-1:0]   bus_fc;
  logic [15:0]       bus_dout;
  logic [15:0]       bus_din = '0;
  logic              bus_ack = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_sizer #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_bus_sizer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_fc(req_fc), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_addr_err(rsp_addr_err), .bus_addr(bus_addr),
    .bus_as(bus_as), .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_rw(bus_rw),
    .bus_fc(bus_fc), .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL R12 watchdog act=%0d exp=%0d", cyc, 20000);
      summary();
    end
  end

  // Presents a request for one cycle; returns at the negedge after acceptance.
  task automatic do_req(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                        input logic wr, input logic [31:0] wd, input logic [FC_W-1:0] fc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_fc = fc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Checks a running bus cycle, holds it for waits cycles, then acknowledges.
  task automatic bus_cycle(input string tag, input logic [ADDR_W-2:0] ea, input logic eu,
                           input logic el, input logic erw, input logic [15:0] ed,
                           input logic [FC_W-1:0] efc, input int waits, input logic [15:0] din);
    chk({tag, " R5 as"}, 32'(bus_as), 32'd1);
    chk({tag, " R4 addr"}, 32'(bus_addr), 32'(ea));
    chk({tag, " R3 uds"}, 32'(bus_uds), 32'(eu));
    chk({tag, " R3 lds"}, 32'(bus_lds), 32'(el));
    chk({tag, " R8 rw"}, 32'(bus_rw), 32'(erw));
    chk({tag, " R11 fc"}, 32'(bus_fc), 32'(efc));
    chk({tag, " R10 ready"}, 32'(req_ready), 32'd0);
    if (!erw) chk({tag, " R9 dout"}, 32'(bus_dout), 32'(ed));
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk({tag, " R5 hold as"}, 32'(bus_as), 32'd1);
      chk({tag, " R5 hold addr"}, 32'(bus_addr), 32'(ea));
      if (!erw) chk({tag, " R5 hold dout"}, 32'(bus_dout), 32'(ed));
    end
    bus_ack = 1'b1; bus_din = din;
    @(negedge clk);
    bus_ack = 1'b0;
  endtask

  task automatic finish_ok(input string tag, input logic [31:0] erd, input logic is_rd);
    chk({tag, " R12 done"}, 32'(rsp_done), 32'd1);
    chk({tag, " R12 as low"}, 32'(bus_as), 32'd0);
    chk({tag, " R10 ready back"}, 32'(req_ready), 32'd1);
    if (is_rd) chk({tag, " R9 rdata"}, rsp_rdata, erd);
    @(negedge clk);
    chk({tag, " R12 done pulse"}, 32'(rsp_done), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 as", 32'(bus_as), 32'd0);
    chk("R1 uds", 32'(bus_uds), 32'd0);
    chk("R1 lds", 32'(bus_lds), 32'd0);
    chk("R1 rw", 32'(bus_rw), 32'd1);
    chk("R1 done", 32'(rsp_done), 32'd0);
    chk("R1 err", 32'(rsp_addr_err), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_byte_reads();
    do_req(12'h124, 2'b00, 1'b0, 32'h0, 3'd5);
    bus_cycle("R3 even byte rd", 11'h092, 1'b1, 1'b0, 1'b1, 16'h0, 3'd5, 2, 16'hAB12);
    finish_ok("R9 even byte rd", 32'h0000_00AB, 1'b1);
    do_req(12'h125, 2'b00, 1'b0, 32'h0, 3'd1);
    bus_cycle("R3 odd byte rd", 11'h092, 1'b0, 1'b1, 1'b1, 16'h0, 3'd1, 0, 16'hAB12);
    finish_ok("R9 odd byte rd", 32'h0000_0012, 1'b1);
  endtask

  task automatic t_byte_word_writes();
    do_req(12'h003, 2'b00, 1'b1, 32'h1111_225A, 3'd2);
    bus_cycle("R9 byte wr", 11'h001, 1'b0, 1'b1, 1'b0, 16'h5A5A, 3'd2, 1, 16'h0);
    finish_ok("R9 byte wr", 32'h0, 1'b0);
    do_req(12'h200, 2'b01, 1'b1, 32'h7777_BEEF, 3'd3);
    bus_cycle("R9 word wr", 11'h100, 1'b1, 1'b1, 1'b0, 16'hBEEF, 3'd3, 0, 16'h0);
    finish_ok("R9 word wr", 32'h0, 1'b0);
    do_req(12'h044, 2'b01, 1'b0, 32'h0, 3'd6);
    bus_cycle("R9 word rd", 11'h022, 1'b1, 1'b1, 1'b1, 16'h0, 3'd6, 3, 16'hC0DE);
    finish_ok("R9 word rd", 32'h0000_C0DE, 1'b1);
  endtask

  task automatic t_long_read(input logic [ADDR_W-1:0] a, input logic [ADDR_W-2:0] w1,
                             input logic [ADDR_W-2:0] w2, input string tag);
    do_req(a, 2'b10, 1'b0, 32'h0, 3'd6);
    bus_cycle({tag, " R6 half1"}, w1, 1'b1, 1'b1, 1'b1, 16'h0, 3'd6, 1, 16'h1234);
    chk({tag, " R6 gap as"}, 32'(bus_as), 32'd0);
    chk({tag, " R7 no early done"}, 32'(rsp_done), 32'd0);
    chk({tag, " R10 ready gap"}, 32'(req_ready), 32'd0);
    @(negedge clk);
    bus_cycle({tag, " R6 half2"}, w2, 1'b1, 1'b1, 1'b1, 16'h0, 3'd6, 2, 16'h5678);
    finish_ok({tag, " R7 long rd"}, 32'h1234_5678, 1'b1);
  endtask

  task automatic t_long_write_ignore();
    do_req(12'h300, 2'b11, 1'b1, 32'hDEAD_BEEF, 3'd4);
    // competing request while busy: must not disturb the running access (R10)
    req_valid = 1'b1; req_addr = 12'h0A1; req_size = 2'b00; req_write = 1'b0; req_fc = 3'd0;
    bus_cycle("R8 long wr half1", 11'h180, 1'b1, 1'b1, 1'b0, 16'hDEAD, 3'd4, 2, 16'h0);
    chk("R8 rw in gap", 32'(bus_rw), 32'd0);
    @(negedge clk);
    bus_cycle("R8 long wr half2", 11'h181, 1'b1, 1'b1, 1'b0, 16'hBEEF, 3'd4, 1, 16'h0);
    req_valid = 1'b0;
    finish_ok("R8 long wr", 32'h0, 1'b0);
    chk("R10 ignored req no cycle", 32'(bus_as), 32'd0);
  endtask

  task automatic t_misaligned(input logic [1:0] sz, input logic [ADDR_W-1:0] a, input string tag);
    do_req(a, sz, 1'b1, 32'h0, 3'd1);
    chk({tag, " R2 err"}, 32'(rsp_addr_err), 32'd1);
    chk({tag, " R2 no as"}, 32'(bus_as), 32'd0);
    chk({tag, " R2 ready"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    chk({tag, " R2 err pulse"}, 32'(rsp_addr_err), 32'd0);
    chk({tag, " R2 still no as"}, 32'(bus_as), 32'd0);
    chk({tag, " R2 no done"}, 32'(rsp_done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_reads();
    t_byte_word_writes();
    t_long_read(12'h100, 11'h080, 11'h081, "R4 long");
    t_long_read(12'hFFE, 11'h7FF, 11'h000, "R4 wrap");
    t_long_write_ignore();
    t_misaligned(2'b01, 12'h101, "word odd");
    t_misaligned(2'b10, 12'h103, "long odd");
    summary();
  end
endmodule